// File: doc/BRIEF.md
# Potentiometer Data Register Bank Controller

This block keeps the stored wiper settings of a four-pot digital potentiometer: for every pot, four 6-bit data registers that stand in for nonvolatile cells and are built from flops. The serial front end hands it fully decoded commands. There are three kinds: a direct write of a host byte into one register, a copy of one pot's wiper counter into one of its own registers, and a copy of all wiper counters, each into the selected register of its own pot, in a single store.

A command is only held as pending when it arrives. The store happens when chip select rises at the end of the frame, and only if the write-protect pin is high at that moment. Each store opens a busy window whose length is a parameter in clock cycles. The write-in-progress flag is high for the whole window, and storing commands that arrive during it are dropped. Reads of any register are always available. Register 0 of every pot is also driven out as the recall value for the wiper counters at power-up.

Top module: `nv_bank_ctrl`

## Requirements
- R1: After reset every data register holds DR_INIT and `wip_o` is 0.
- R2: `rd_data_o` shows the register addressed by `rd_pot_i` and `rd_reg_i` in the same cycle, whether or not a store is in progress.
- R3: A direct write (`cmd_op_i` = 0) of `cmd_data_i` into register `cmd_reg_i` of pot `cmd_pot_i` leaves every register unchanged until `cs_rise_i` is sampled high. It is visible from the clock edge that samples `cs_rise_i`.
- R4: A single transfer (`cmd_op_i` = 1) stores the wiper value of pot `cmd_pot_i` into that pot's register `cmd_reg_i`. The wiper value used is the one present on `wcr_i` when the command was accepted, and later changes to `wcr_i` do not alter it. Pot p's wiper value sits at `wcr_i[p*6 +: 6]`.
- R5: A global transfer (`cmd_op_i` = 2) stores each pot's wiper value into register `cmd_reg_i` of that same pot, all in one store. Other registers are untouched.
- R6: A store raises `wip_o` on the edge that performs it, and `wip_o` stays high for exactly BUSY_CYCLES cycles.
- R7: If `wp_ni` is low when `cs_rise_i` is sampled, the pending command is discarded: no register changes and `wip_o` stays low.
- R8: A command accepted while `wip_o` is high is ignored, even if `cs_rise_i` follows, and it leaves nothing pending once the window ends.
- R9: Only the last command of a frame is stored. A `cs_rise_i` with nothing pending does nothing, and a `cmd_op_i` of 3 is never made pending.
- R10: `recall_o[p*6 +: 6]` always equals register 0 of pot p.
- R11: A command presented in the same cycle as `cs_rise_i` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle strobe: a complete command was decoded |
| cmd_op_i | input | 2 | 0 direct write, 1 single transfer, 2 global transfer, 3 unused |
| cmd_pot_i | input | 2 | Target pot |
| cmd_reg_i | input | 2 | Target register |
| cmd_data_i | input | 6 | Host data for a direct write |
| wcr_i | input | 24 | Wiper counter values of all pots, pot p at bits p*6 +: 6 |
| cs_rise_i | input | 1 | One-cycle strobe: chip select rose (frame end) |
| wp_ni | input | 1 | Write protect, low blocks stores |
| rd_pot_i | input | 2 | Read pot select |
| rd_reg_i | input | 2 | Read register select |
| rd_data_o | output | 6 | Selected register contents |
| recall_o | output | 24 | Register 0 of each pot, pot p at bits p*6 +: 6 |
| wip_o | output | 1 | Store in progress |

## Verification
The bench builds the block with BUSY_CYCLES set to 5 instead of the default of 10 ms worth of clock cycles. With that setting the whole busy window can be counted cycle by cycle, and a complete command followed by a frame end fits inside a single window, which makes the drop-while-busy rule reachable. DR_INIT is set to a mid-scale value of 0x20, so a register that was never stored is distinguishable from a zeroed one. The wiper bus is changed between command acceptance and frame end, to show that transfers use the snapshot taken when the command was accepted.

// File: rtl/nv_bank_pkg.sv
package nv_bank_pkg;
  typedef enum logic [1:0] {
    OP_WR_DR   = 2'd0,
    OP_XFR_ONE = 2'd1,
    OP_XFR_ALL = 2'd2,
    OP_NONE    = 2'd3
  } nv_op_e;
endpackage

// File: rtl/nv_cmd_capture.sv
module nv_cmd_capture
  import nv_bank_pkg::*;
#(
  parameter int NUM_POTS = 4,
  parameter int DATA_W   = 6,
  parameter int PW       = 2,
  parameter int RW       = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_valid_i,
  input  nv_op_e                     cmd_op_i,
  input  logic [PW-1:0]              cmd_pot_i,
  input  logic [RW-1:0]              cmd_reg_i,
  input  logic [DATA_W-1:0]          cmd_data_i,
  input  logic [NUM_POTS*DATA_W-1:0] wcr_i,
  input  logic                       cs_rise_i,
  input  logic                       busy_i,
  output logic                       pend_o,
  output logic [NUM_POTS-1:0]        mask_o,
  output logic [RW-1:0]              reg_o,
  output logic [NUM_POTS*DATA_W-1:0] vec_o
);
  localparam logic [NUM_POTS-1:0] ONE_HOT0 = NUM_POTS'(1);

  logic accept;
  assign accept = cmd_valid_i && !busy_i && !cs_rise_i && (cmd_op_i != OP_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      mask_o <= '0;
      reg_o  <= '0;
      vec_o  <= '0;
    end else if (cs_rise_i) begin
      pend_o <= 1'b0;
    end else if (accept) begin
      pend_o <= 1'b1;
      reg_o  <= cmd_reg_i;
      unique case (cmd_op_i)
        OP_WR_DR: begin
          mask_o <= ONE_HOT0 << cmd_pot_i;
          vec_o  <= {NUM_POTS{cmd_data_i}};
        end
        OP_XFR_ONE: begin
          mask_o <= ONE_HOT0 << cmd_pot_i;
          vec_o  <= wcr_i;
        end
        default: begin
          mask_o <= '1;
          vec_o  <= wcr_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/nv_busy_timer.sv
module nv_busy_timer #(
  parameter int BUSY_CYCLES = 500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nv_reg_array.sv
module nv_reg_array #(
  parameter int              NUM_POTS = 4,
  parameter int              NUM_REGS = 4,
  parameter int              DATA_W   = 6,
  parameter int              RW       = 2,
  parameter logic [DATA_W-1:0] DR_INIT = '0
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                commit_i,
  input  logic [NUM_POTS-1:0]                 mask_i,
  input  logic [RW-1:0]                       reg_i,
  input  logic [NUM_POTS*DATA_W-1:0]          vec_i,
  output logic [NUM_POTS*NUM_REGS*DATA_W-1:0] dr_o
);
  for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          q <= DR_INIT;
        else if (commit_i && mask_i[p] && (reg_i == RW'(r)))
          q <= vec_i[p*DATA_W +: DATA_W];
      end
      assign dr_o[(p*NUM_REGS+r)*DATA_W +: DATA_W] = q;
    end
  end
endmodule

// File: rtl/nv_bank_ctrl.sv
module nv_bank_ctrl
  import nv_bank_pkg::*;
#(
  parameter int                NUM_POTS    = 4,
  parameter int                NUM_REGS    = 4,
  parameter int                DATA_W      = 6,
  parameter int                BUSY_CYCLES = 500_000,
  parameter logic [DATA_W-1:0] DR_INIT     = '0,
  localparam int               PW          = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1,
  localparam int               RW          = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_valid_i,
  input  logic [1:0]                 cmd_op_i,
  input  logic [PW-1:0]              cmd_pot_i,
  input  logic [RW-1:0]              cmd_reg_i,
  input  logic [DATA_W-1:0]          cmd_data_i,
  input  logic [NUM_POTS*DATA_W-1:0] wcr_i,
  input  logic                       cs_rise_i,
  input  logic                       wp_ni,
  input  logic [PW-1:0]              rd_pot_i,
  input  logic [RW-1:0]              rd_reg_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [NUM_POTS*DATA_W-1:0] recall_o,
  output logic                       wip_o
);
  logic                                pend;
  logic [NUM_POTS-1:0]                 pend_mask;
  logic [RW-1:0]                       pend_reg;
  logic [NUM_POTS*DATA_W-1:0]          pend_vec;
  logic                                commit;
  logic [NUM_POTS*NUM_REGS*DATA_W-1:0] dr_flat;
  logic [DATA_W-1:0]                   dr_arr [NUM_POTS][NUM_REGS];

  nv_cmd_capture #(
    .NUM_POTS(NUM_POTS), .DATA_W(DATA_W), .PW(PW), .RW(RW)
  ) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (nv_op_e'(cmd_op_i)),
    .cmd_pot_i  (cmd_pot_i),
    .cmd_reg_i  (cmd_reg_i),
    .cmd_data_i (cmd_data_i),
    .wcr_i      (wcr_i),
    .cs_rise_i  (cs_rise_i),
    .busy_i     (wip_o),
    .pend_o     (pend),
    .mask_o     (pend_mask),
    .reg_o      (pend_reg),
    .vec_o      (pend_vec)
  );

  // store only at frame end, unprotected, and outside a busy window
  assign commit = cs_rise_i && pend && wp_ni && !wip_o;

  nv_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(commit),
    .busy_o (wip_o)
  );

  nv_reg_array #(
    .NUM_POTS(NUM_POTS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
    .RW(RW), .DR_INIT(DR_INIT)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .mask_i  (pend_mask),
    .reg_i   (pend_reg),
    .vec_i   (pend_vec),
    .dr_o    (dr_flat)
  );

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_view
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_r
      assign dr_arr[p][r] = dr_flat[(p*NUM_REGS+r)*DATA_W +: DATA_W];
    end
    assign recall_o[p*DATA_W +: DATA_W] = dr_arr[p][0];
  end

  assign rd_data_o = dr_arr[rd_pot_i][rd_reg_i];
endmodule

// File: rtl/nv_bank_chk.sv
module nv_bank_chk #(
  parameter int NUM_POTS    = 4,
  parameter int NUM_REGS    = 4,
  parameter int DATA_W      = 6,
  parameter int BUSY_CYCLES = 500_000,
  parameter int PW          = 2,
  parameter int RW          = 2
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic                                cs_rise_i,
  input logic                                wp_ni,
  input logic                                wip_o,
  input logic [NUM_POTS*NUM_REGS*DATA_W-1:0] dr_flat,
  input logic [NUM_POTS*DATA_W-1:0]          recall_o,
  input logic [PW-1:0]                       rd_pot_i,
  input logic [RW-1:0]                       rd_reg_i,
  input logic [DATA_W-1:0]                   rd_data_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    run_q <= 0;
    else if (wip_o) run_q <= run_q + 1;
    else            run_q <= 0;
  end

  p_wip_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_o) |-> $past(cs_rise_i && wp_ni));

  p_wip_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= BUSY_CYCLES);

  p_dr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_rise_i && wp_ni) |=> $stable(dr_flat));

  p_wp_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && !wp_ni) |=> ($stable(dr_flat) && !$rose(wip_o)));

  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wip_o && cs_rise_i) |=> $stable(dr_flat));

  p_recall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_reg_i == '0) |-> (rd_data_o == recall_o[int'(rd_pot_i)*DATA_W +: DATA_W]));
endmodule

bind nv_bank_ctrl nv_bank_chk #(
  .NUM_POTS(NUM_POTS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
  .BUSY_CYCLES(BUSY_CYCLES), .PW(PW), .RW(RW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_rise_i(cs_rise_i),
  .wp_ni    (wp_ni),
  .wip_o    (wip_o),
  .dr_flat  (dr_flat),
  .recall_o (recall_o),
  .rd_pot_i (rd_pot_i),
  .rd_reg_i (rd_reg_i),
  .rd_data_o(rd_data_o)
);

// File: tb/nv_bank_ctrl_bench.sv
module nv_bank_ctrl_bench;
  localparam int NP = 4, NR = 4, DW = 6, BUSY = 5;
  localparam logic [DW-1:0] INIT = 6'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cs_rise = 1'b0, wp_n = 1'b1;
  logic [1:0] cmd_op = '0, cmd_pot = '0, cmd_reg = '0, rd_pot = '0, rd_reg = '0;
  logic [DW-1:0] cmd_data = '0, rd_data;
  logic [NP*DW-1:0] wcr = '0, recall;
  logic wip;

  nv_bank_ctrl #(
    .NUM_POTS(NP), .NUM_REGS(NR), .DATA_W(DW), .BUSY_CYCLES(BUSY), .DR_INIT(INIT)
  ) u_nv_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_pot_i(cmd_pot), .cmd_reg_i(cmd_reg), .cmd_data_i(cmd_data), .wcr_i(wcr),
    .cs_rise_i(cs_rise), .wp_ni(wp_n), .rd_pot_i(rd_pot), .rd_reg_i(rd_reg),
    .rd_data_o(rd_data), .recall_o(recall), .wip_o(wip)
  );

  always #10 clk = ~clk;

  typedef struct {
    int pot;
    int rg;
    logic [DW-1:0] exp;
    string tag;
  } item_t;

  item_t sb_q[$];
  int outstanding = 0;
  int checks = 0, errors = 0;
  logic [DW-1:0] m [NP][NR];

  task automatic expect_rd(int p, int r, string tag);
    item_t it;
    it.pot = p; it.rg = r; it.exp = m[p][r]; it.tag = tag;
    sb_q.push_back(it);
    outstanding++;
  endtask

  task automatic check_all(string tag);
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NR; r++) expect_rd(p, r, tag);
  endtask

  task automatic flush();
    wait (outstanding == 0);
  endtask

  // monitor: drives the read address, compares against the model snapshot
  initial begin
    forever begin
      item_t it;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      @(negedge clk);
      rd_pot = 2'(it.pot);
      rd_reg = 2'(it.rg);
      #2;
      checks++;
      if (rd_data !== it.exp) begin
        errors++;
        $display("FAIL %s pot %0d reg %0d actual %h expected %h",
                 it.tag, it.pot, it.rg, rd_data, it.exp);
      end
      outstanding--;
    end
  end

  task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(logic [1:0] op, int p, int r, logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pot = 2'(p); cmd_reg = 2'(r); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_cs();
    @(negedge clk);
    cs_rise = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0;
  endtask

  task automatic measure_busy(output int n);
    n = 0;
    while (wip && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_recall(string tag);
    for (int p = 0; p < NP; p++)
      check_val(tag, 32'(recall[p*DW +: DW]), 32'(m[p][0]));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NR; r++) m[p][r] = INIT;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 recall
    check_val("R1 wip after reset", 32'(wip), 0);
    check_all("R1");
    flush();
    check_recall("R10 reset");

    // R3 deferred direct write, R6 window length
    send_cmd(2'd0, 2, 1, 6'h15);
    repeat (2) @(negedge clk);
    expect_rd(2, 1, "R3 before frame end");
    flush();
    check_val("R3 no wip before frame end", 32'(wip), 0);
    pulse_cs();
    m[2][1] = 6'h15;
    measure_busy(n);
    check_val("R6 busy length", 32'(n), BUSY);
    check_all("R3");
    flush();

    // R8 command during busy is ignored
    send_cmd(2'd0, 3, 3, 6'h01);
    pulse_cs();
    m[3][3] = 6'h01;
    check_val("R6 wip high", 32'(wip), 1);
    send_cmd(2'd0, 0, 0, 6'h3F);
    pulse_cs();
    while (wip) @(negedge clk);
    pulse_cs();
    check_val("R8 no store after window", 32'(wip), 0);
    check_all("R8");
    flush();

    // R4 single transfer uses snapshot at acceptance
    wcr = {6'h11, 6'h22, 6'h33, 6'h0A};
    send_cmd(2'd1, 1, 3, 6'h00);
    wcr = {6'h01, 6'h02, 6'h03, 6'h04};
    pulse_cs();
    m[1][3] = 6'h33;
    measure_busy(n);
    check_all("R4");
    flush();

    // R5 global transfer
    wcr = {6'h3E, 6'h2D, 6'h1C, 6'h0B};
    send_cmd(2'd2, 0, 2, 6'h00);
    wcr = '0;
    pulse_cs();
    m[0][2] = 6'h0B; m[1][2] = 6'h1C; m[2][2] = 6'h2D; m[3][2] = 6'h3E;
    measure_busy(n);
    check_val("R5 single window", 32'(n), BUSY);
    check_all("R5");
    flush();

    // R7 write protect
    wp_n = 1'b0;
    send_cmd(2'd0, 0, 1, 6'h07);
    pulse_cs();
    check_val("R7 wip stays low", 32'(wip), 0);
    @(negedge clk);
    check_val("R7 wip stays low later", 32'(wip), 0);
    wp_n = 1'b1;
    pulse_cs();
    check_val("R7 command discarded", 32'(wip), 0);
    check_all("R7");
    flush();

    // R9 last command wins, empty frame end, unused op
    send_cmd(2'd0, 0, 2, 6'h01);
    send_cmd(2'd0, 3, 0, 6'h2A);
    pulse_cs();
    m[3][0] = 6'h2A;
    measure_busy(n);
    check_val("R9 last command stored", 32'(n), BUSY);
    pulse_cs();
    check_val("R9 empty frame end", 32'(wip), 0);
    send_cmd(2'd3, 1, 1, 6'h3C);
    pulse_cs();
    check_val("R9 unused op", 32'(wip), 0);
    check_all("R9");
    flush();
    check_recall("R10 after store");

    // R11 command in the frame-end cycle is dropped
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_pot = 2'd1; cmd_reg = 2'd0; cmd_data = 6'h2F;
    cs_rise = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cs_rise = 1'b0;
    check_val("R11 no store", 32'(wip), 0);
    pulse_cs();
    check_val("R11 nothing pending", 32'(wip), 0);
    check_all("R11");
    flush();

    // R2 read during busy
    send_cmd(2'd0, 1, 2, 6'h39);
    pulse_cs();
    m[1][2] = 6'h39;
    expect_rd(1, 2, "R2 read while busy");
    flush();
    while (wip) @(negedge clk);

    finish_run();
  end
endmodule